// File: doc/BRIEF.md
# Four-Channel Equalizer Setting Selector

This block produces the analog settings of four equalizer lanes: a 4-bit peaking code, a 2-bit flat-gain code, a 2-bit output-amplitude code and a power-down bit for each lane. The settings come from one of two sources:

- **Pins:** three global three-level control pins, already decoded to low, open or high. Their meaning depends on a short/long channel strap.
- **Registers:** the per-lane configuration registers of the serial bus.

A bus-enable strap, sampled at power-on reset, chooses between the two.

A three-level enable pin has three roles:

- Low holds the serial interface in reset. The block raises a hold output that clears the registers and blocks bus traffic, and it treats the register contents as their defaults.
- In pin mode, high and open power all lanes down or up at any time.
- In bus mode, the enable level is captured only on leaving power-on reset or an enable-low reset, and then kept.

Every output is a flop, so settings move one clock after their cause and never glitch.

Top module: `chanctl_mux`

## Requirements
- R1: Three-level pins are coded 2'b00 low, 2'b01 open, 2'b10 high; 2'b11 counts as open. With app_short=0 (long), the peaking pin gives code 4'b1110 for high, 4'b1001 for open and 4'b0101 for low, on every lane.
- R2: With app_short=1 (short), the peaking pin gives 4'b1001 for high, 4'b0101 for open and 4'b0011 for low.
- R3: The flat-gain pin gives 2'b11/2'b10/2'b01 for high/open/low in long mode, and 2'b10/2'b01/2'b00 in short mode.
- R4: The amplitude pin gives 2'b11/2'b10/2'b01 for high/open/low in both modes.
- R5: In pin mode (strap 0 at power-on), reg_override, reg_off and cfg_regs have no effect: all lanes follow the pins.
- R6: In bus mode, reg_override=0 selects the pin settings for all lanes. reg_override=1 gives lane c the byte cfg_regs[8c+7:8c], decoded as peaking [7:4], flat gain [3:2] and amplitude [1:0].
- R7: In bus mode, reg_off[c]=1 powers down lane c only; 0 leaves it to the global power state.
- R8: While en_pin is low, bus_hold is 1, every lane is powered down, and the register inputs are treated as defaults, so lane codes follow the pins.
- R9: In pin mode, en_pin high powers every lane down and open powers every lane up, tracking the pin at any time.
- R10: In bus mode, the global power state is taken from en_pin (high = down, open = up) in the first cycle after power-on reset or an enable-low reset ends. Later changes of en_pin between high and open have no effect.
- R11: bus_strap is sampled only while rst is 1; changes afterwards have no effect.
- R12: While rst is 1, outputs are: all codes 0, all lanes powered down, bus_hold 1. Every output changes one clock edge after the input that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| peak_pin | input | 2 | Decoded peaking control pin level |
| gain_pin | input | 2 | Decoded flat-gain control pin level |
| amp_pin | input | 2 | Decoded output-amplitude control pin level |
| en_pin | input | 2 | Decoded enable / reset pin level |
| app_short | input | 1 | Channel strap: 1 short, 0 long |
| bus_strap | input | 1 | Bus-control strap: 1 bus mode, 0 pin mode |
| cfg_regs | input | 32 | Per-lane configuration bytes, lane c at [8c+7:8c] |
| reg_override | input | 1 | Register-source select from the control register |
| reg_off | input | 4 | Per-lane off bits, lane c at bit c |
| ch_peak | output | 16 | Peaking codes, lane c at [4c+3:4c] |
| ch_gain | output | 8 | Flat-gain codes, lane c at [2c+1:2c] |
| ch_amp | output | 8 | Amplitude codes, lane c at [2c+1:2c] |
| ch_pd | output | 4 | Lane power-down, lane c at bit c |
| bus_hold | output | 1 | Internal reset: clears registers and blocks the bus |

## Verification
The bench covers every row of the three pin tables in both channel modes, including the reserved 2'b11 code. A swapped row or a mode-blind table would show up as a wrong code on all four lanes.

It moves en_pin between high and open after a bus-mode reset. A design that tracks the pin live in bus mode would then toggle lane power when it should not.

It drives the registers with override set during an enable-low hold, and it changes bus_strap after reset. A design that lets the registers through during the hold, or that re-reads the strap, would change lane codes.

It gives lanes distinct register bytes and sets off bits on alternate lanes. A wrong byte slice, or an off bit mapped to the wrong lane, would show as a misplaced setting.

// File: rtl/chanctl_pkg.sv
package chanctl_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_OPEN = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_RSVD = 2'b11
  } tri_lvl_e;

  localparam int PEAK_W = 4;
  localparam int GAIN_W = 2;
  localparam int AMP_W  = 2;
  localparam int CFG_W  = PEAK_W + GAIN_W + AMP_W;

  typedef struct packed {
    logic [PEAK_W-1:0] peak;
    logic [GAIN_W-1:0] gain;
    logic [AMP_W-1:0]  amp;
  } ch_cfg_t;

  function automatic logic lvl_is_high(input logic [1:0] l);
    return l == LVL_HIGH;
  endfunction

  function automatic logic lvl_is_low(input logic [1:0] l);
    return l == LVL_LOW;
  endfunction
endpackage

// File: rtl/chanctl_pin_decode.sv
module chanctl_pin_decode
  import chanctl_pkg::*;
(
  input  logic [1:0] peak_pin,
  input  logic [1:0] gain_pin,
  input  logic [1:0] amp_pin,
  input  logic       app_short,
  output ch_cfg_t    pin_cfg
);
  // Pick one of three table entries; the reserved code falls on "open".
  function automatic logic [PEAK_W-1:0] pick4(input logic [1:0] l,
      input logic [PEAK_W-1:0] hi, input logic [PEAK_W-1:0] op,
      input logic [PEAK_W-1:0] lo);
    if (lvl_is_high(l))     return hi;
    else if (lvl_is_low(l)) return lo;
    else                    return op;
  endfunction

  function automatic logic [1:0] pick2(input logic [1:0] l,
      input logic [1:0] hi, input logic [1:0] op, input logic [1:0] lo);
    if (lvl_is_high(l))     return hi;
    else if (lvl_is_low(l)) return lo;
    else                    return op;
  endfunction

  always_comb begin
    if (app_short) begin
      pin_cfg.peak = pick4(peak_pin, 4'b1001, 4'b0101, 4'b0011);
      pin_cfg.gain = pick2(gain_pin, 2'b10, 2'b01, 2'b00);
    end else begin
      pin_cfg.peak = pick4(peak_pin, 4'b1110, 4'b1001, 4'b0101);
      pin_cfg.gain = pick2(gain_pin, 2'b11, 2'b10, 2'b01);
    end
    pin_cfg.amp = pick2(amp_pin, 2'b11, 2'b10, 2'b01);
  end

  // R4: the amplitude path never yields the unused lowest code from pins
  always_comb begin
    a_amp_nonzero_r4: assert (pin_cfg.amp != 2'b00);
  end
endmodule

// File: rtl/chanctl_power.sv
module chanctl_power
  import chanctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] en_pin,
  input  logic       bus_strap,
  output logic       mode_bus,
  output logic       hold,
  output logic       global_pd,
  output logic       bus_hold
);
  logic mode_bus_q;
  logic arm_q;
  logic pd_lat_q;
  logic en_low, en_high;

  assign en_low  = lvl_is_low(en_pin);
  assign en_high = lvl_is_high(en_pin);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_bus_q <= bus_strap;
      arm_q      <= 1'b1;
      pd_lat_q   <= 1'b1;
    end else if (en_low) begin
      arm_q <= 1'b1;
    end else if (arm_q) begin
      pd_lat_q <= en_high;
      arm_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_hold <= 1'b1;
    else     bus_hold <= en_low;
  end

  assign mode_bus = mode_bus_q;
  assign hold     = en_low;

  always_comb begin
    if (en_low)          global_pd = 1'b1;
    else if (!mode_bus_q) global_pd = en_high;
    else if (arm_q)      global_pd = en_high;
    else                 global_pd = pd_lat_q;
  end

  // R11: strap copy is frozen outside power-on reset
  p_strap_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_bus_q));

  // R10: a capture cycle always clears the pending capture
  p_capture_once_r10: assert property (@(posedge clk) disable iff (rst)
    (arm_q && !en_low) |=> !arm_q);
endmodule

// File: rtl/chanctl_chan_sel.sv
module chanctl_chan_sel
  import chanctl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ch_cfg_t               pin_cfg,
  input  logic [NCH*CFG_W-1:0]  cfg_regs,
  input  logic                  reg_override,
  input  logic [NCH-1:0]        reg_off,
  input  logic                  mode_bus,
  input  logic                  hold,
  input  logic                  global_pd,
  output logic [NCH*PEAK_W-1:0] ch_peak,
  output logic [NCH*GAIN_W-1:0] ch_gain,
  output logic [NCH*AMP_W-1:0]  ch_amp,
  output logic [NCH-1:0]        ch_pd
);
  logic regs_live;
  logic use_reg;

  // Registers only count in bus mode and outside the enable-low hold.
  assign regs_live = mode_bus && !hold;
  assign use_reg   = regs_live && reg_override;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ch_cfg_t reg_cfg, sel_cfg;
    logic    off_eff;

    assign reg_cfg = ch_cfg_t'(cfg_regs[c*CFG_W +: CFG_W]);
    assign sel_cfg = use_reg ? reg_cfg : pin_cfg;
    assign off_eff = regs_live && reg_off[c];

    always_ff @(posedge clk) begin
      if (rst) begin
        ch_peak[c*PEAK_W +: PEAK_W] <= '0;
        ch_gain[c*GAIN_W +: GAIN_W] <= '0;
        ch_amp[c*AMP_W +: AMP_W]    <= '0;
        ch_pd[c]                    <= 1'b1;
      end else begin
        ch_peak[c*PEAK_W +: PEAK_W] <= sel_cfg.peak;
        ch_gain[c*GAIN_W +: GAIN_W] <= sel_cfg.gain;
        ch_amp[c*AMP_W +: AMP_W]    <= sel_cfg.amp;
        ch_pd[c]                    <= global_pd || off_eff;
      end
    end

    // R5: when the pins are the source, every lane carries lane 0's codes
    p_pins_uniform_r5: assert property (@(posedge clk) disable iff (rst)
      !use_reg |=> (ch_peak[c*PEAK_W +: PEAK_W] == ch_peak[PEAK_W-1:0]) &&
                   (ch_gain[c*GAIN_W +: GAIN_W] == ch_gain[GAIN_W-1:0]) &&
                   (ch_amp[c*AMP_W +: AMP_W] == ch_amp[AMP_W-1:0]));
  end
endmodule

// File: rtl/chanctl_mux.sv
module chanctl_mux
  import chanctl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            peak_pin,
  input  logic [1:0]            gain_pin,
  input  logic [1:0]            amp_pin,
  input  logic [1:0]            en_pin,
  input  logic                  app_short,
  input  logic                  bus_strap,
  input  logic [NCH*CFG_W-1:0]  cfg_regs,
  input  logic                  reg_override,
  input  logic [NCH-1:0]        reg_off,
  output logic [NCH*PEAK_W-1:0] ch_peak,
  output logic [NCH*GAIN_W-1:0] ch_gain,
  output logic [NCH*AMP_W-1:0]  ch_amp,
  output logic [NCH-1:0]        ch_pd,
  output logic                  bus_hold
);
  ch_cfg_t pin_cfg;
  logic    mode_bus, hold, global_pd;

  chanctl_pin_decode u_dec (
    .peak_pin (peak_pin),
    .gain_pin (gain_pin),
    .amp_pin  (amp_pin),
    .app_short(app_short),
    .pin_cfg  (pin_cfg)
  );

  chanctl_power u_pwr (
    .clk      (clk),
    .rst      (rst),
    .en_pin   (en_pin),
    .bus_strap(bus_strap),
    .mode_bus (mode_bus),
    .hold     (hold),
    .global_pd(global_pd),
    .bus_hold (bus_hold)
  );

  chanctl_chan_sel #(.NCH(NCH)) u_sel (
    .clk         (clk),
    .rst         (rst),
    .pin_cfg     (pin_cfg),
    .cfg_regs    (cfg_regs),
    .reg_override(reg_override),
    .reg_off     (reg_off),
    .mode_bus    (mode_bus),
    .hold        (hold),
    .global_pd   (global_pd),
    .ch_peak     (ch_peak),
    .ch_gain     (ch_gain),
    .ch_amp      (ch_amp),
    .ch_pd       (ch_pd)
  );

  // R8: an enable-low pin forces hold and full power-down on the next edge
  p_enlow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en_pin == 2'b00) |=> (bus_hold && (&ch_pd)));

  // R9: in pin mode a high enable powers every lane down next edge
  p_pinmode_pd_r9: assert property (@(posedge clk) disable iff (rst)
    (!mode_bus && en_pin == 2'b10) |=> (&ch_pd));

  // R12: outside reset, hold drops one edge after enable leaves low
  p_hold_release_r12: assert property (@(posedge clk) disable iff (rst)
    (en_pin != 2'b00) |=> !bus_hold);
endmodule

// File: tb/chanctl_mux_tb.sv
module chanctl_mux_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  peak_pin, gain_pin, amp_pin, en_pin;
  logic        app_short, bus_strap;
  logic [31:0] cfg_regs;
  logic        reg_override;
  logic [3:0]  reg_off;
  logic [15:0] ch_peak;
  logic [7:0]  ch_gain, ch_amp;
  logic [3:0]  ch_pd;
  logic        bus_hold;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chanctl_mux #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .peak_pin(peak_pin), .gain_pin(gain_pin),
    .amp_pin(amp_pin), .en_pin(en_pin), .app_short(app_short),
    .bus_strap(bus_strap), .cfg_regs(cfg_regs), .reg_override(reg_override),
    .reg_off(reg_off), .ch_peak(ch_peak), .ch_gain(ch_gain), .ch_amp(ch_amp),
    .ch_pd(ch_pd), .bus_hold(bus_hold)
  );

  localparam logic [1:0] LO = 2'b00, OP = 2'b01, HI = 2'b10, RS = 2'b11;

  function automatic logic [3:0] exp_peak(input logic [1:0] l, input logic s);
    case (l)
      HI:      return s ? 4'b1001 : 4'b1110;
      LO:      return s ? 4'b0011 : 4'b0101;
      default: return s ? 4'b0101 : 4'b1001;
    endcase
  endfunction

  function automatic logic [1:0] exp_gain(input logic [1:0] l, input logic s);
    case (l)
      HI:      return s ? 2'b10 : 2'b11;
      LO:      return s ? 2'b00 : 2'b01;
      default: return s ? 2'b01 : 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] exp_amp(input logic [1:0] l);
    case (l)
      HI:      return 2'b11;
      LO:      return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_pins(input string req, input logic [1:0] l, input logic s);
    chk({req, " peak"}, ch_peak, {4{exp_peak(l, s)}});
    chk({req, " gain"}, ch_gain, {4{exp_gain(l, s)}});
    chk({req, " amp"},  ch_amp,  {4{exp_amp(l)}});
  endtask

  // R12: power-on reset with a given strap and enable level
  task automatic do_por(input logic strap, input logic [1:0] en);
    @(negedge clk);
    rst = 1'b1; bus_strap = strap; en_pin = en;
    step(); step();
    chk("R12 reset peak", ch_peak, 16'h0);
    chk("R12 reset gain", {ch_gain, ch_amp}, 16'h0);
    chk("R12 reset pd", ch_pd, 4'hF);
    chk("R12 reset hold", bus_hold, 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_tables(input logic s);
    logic [1:0] lv [4] = '{HI, OP, LO, RS};
    app_short = s;
    for (int i = 0; i < 4; i++) begin
      peak_pin = lv[i]; gain_pin = lv[i]; amp_pin = lv[i];
      step();
      if (s) chk_pins("R2 R3 R4 short", lv[i], 1'b1);
      else   chk_pins("R1 R3 R4 long", lv[i], 1'b0);
    end
  endtask

  task automatic t_pin_ignores_regs();
    app_short = 1'b0; peak_pin = HI; gain_pin = LO; amp_pin = OP; en_pin = OP;
    cfg_regs = 32'h1234_5678; reg_override = 1'b1; reg_off = 4'hF;
    step();
    chk("R5 peak", ch_peak, {4{4'b1110}});
    chk("R5 gain", ch_gain, {4{2'b01}});
    chk("R5 pd", ch_pd, 4'h0);
  endtask

  task automatic t_pin_power();
    en_pin = HI; step();
    chk("R9 high pd", ch_pd, 4'hF);
    en_pin = OP; step();
    chk("R9 open pd", ch_pd, 4'h0);
    en_pin = HI; step();
    chk("R9 high again pd", ch_pd, 4'hF);
    en_pin = OP; step();
  endtask

  task automatic t_strap_late();
    bus_strap = 1'b1; reg_override = 1'b1; cfg_regs = 32'hA5A5_A5A5;
    step(); step();
    chk("R11 strap ignored peak", ch_peak, {4{4'b1110}});
    bus_strap = 1'b0;
  endtask

  task automatic t_bus_power();
    reg_override = 1'b0; reg_off = 4'h0;
    do_por(1'b1, HI);
    step();
    chk("R10 captured down", ch_pd, 4'hF);
    en_pin = OP; step(); step();
    chk("R10 later open ignored", ch_pd, 4'hF);
    chk("R10 hold low", bus_hold, 1'b0);
  endtask

  task automatic t_enable_low();
    reg_override = 1'b1; reg_off = 4'h0; cfg_regs = 32'h1122_3344;
    peak_pin = LO; gain_pin = LO; amp_pin = LO; app_short = 1'b0;
    en_pin = LO; step();
    chk("R8 hold", bus_hold, 1'b1);
    chk("R8 pd", ch_pd, 4'hF);
    chk("R8 regs as default", ch_peak, {4{4'b0101}});
    en_pin = OP; step();
    chk("R10 recapture up", ch_pd, 4'h0);
    chk("R8 hold release", bus_hold, 1'b0);
    en_pin = HI; step(); step();
    chk("R10 later high ignored", ch_pd, 4'h0);
    en_pin = OP;
  endtask

  task automatic t_bus_override();
    reg_override = 1'b0; cfg_regs = 32'hF0_1B_6C_E7;
    peak_pin = OP; gain_pin = OP; amp_pin = OP; app_short = 1'b1;
    step();
    chk_pins("R6 override off", OP, 1'b1);
    reg_override = 1'b1; step();
    chk("R6 lane peak", ch_peak, 16'hF16E);
    chk("R6 lane gain", ch_gain, 8'b00_10_11_01);
    chk("R6 lane amp",  ch_amp,  8'b00_11_00_11);
  endtask

  task automatic t_off_bits();
    reg_off = 4'b0101; step();
    chk("R7 off bits", ch_pd, 4'b0101);
    reg_off = 4'b1000; step();
    chk("R7 single lane", ch_pd, 4'b1000);
    reg_off = 4'h0;
  endtask

  initial begin
    rst = 1'b1; peak_pin = OP; gain_pin = OP; amp_pin = OP; en_pin = OP;
    app_short = 1'b0; bus_strap = 1'b0; cfg_regs = '0;
    reg_override = 1'b0; reg_off = '0;
    do_por(1'b0, OP);
    t_tables(1'b0);
    t_tables(1'b1);
    t_pin_ignores_regs();
    t_pin_power();
    t_strap_late();
    t_bus_power();
    t_enable_low();
    t_bus_override();
    t_off_bits();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule